// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block turns the decoded memory-operand fields of an instruction into a 64-bit effective address. It takes the two mode bits and three register-or-memory bits of the operand byte, the scale, index and base fields of the optional scaled-index byte, the two register-extension bits that widen the index and base numbers to four bits, and a raw displacement. From these it drives two register-number outputs to an external register file. It adds the returned base and index values to the displacement, or adds the displacement to the address of the next instruction.

The result is registered and appears one cycle after the request. One flag marks a request that needs memory, which is an ordinary operand. Another flag marks an address-only request, whose address is written back as a register result with no memory access. Two further flags report whether a base register and an index register took part in the sum. A request for 32-bit address size truncates the sum to 32 bits and zero-extends it. Segmentation, paging and canonical-address checks belong to other blocks.

Top module: `eag_top`

## Requirements
- R1: While reset is low and after it, until the first request, `ea_valid`, `mem_req`, `lea_done`, `base_used`, `index_used` are 0 and `ea` is all zeros.
- R2: With mode 00 and register-or-memory field other than 100 or 101, the address is the value of the register numbered {`rex_b`,`rm_f`}; `base_used`=1 and `index_used`=0.
- R3: Mode 01 adds `disp_raw[7:0]` sign-extended to 64 bits (upper raw bits ignored); mode 10 adds all 32 bits of `disp_raw` sign-extended; the sum wraps modulo 2^64.
- R4: Register-or-memory field 100 selects the scaled-index form: address = base + (index << `sib_scale`) + displacement, with `sib_scale` 0..3 meaning factors 1, 2, 4, 8.
- R5: An index number {`rex_x`,`sib_index`} equal to 4 adds no index and gives `index_used`=0; number 12 (`rex_x`=1) is an ordinary index.
- R6: `base_sel` is {`rex_b`, base field} and `index_sel` is {`rex_x`,`sib_index`}, combinationally in the request cycle, so registers 8..15 are reachable.
- R7: Mode 00 with register-or-memory field 101 (any `rex_b`) gives address = `cur_ip` + `insn_len` + sign-extended 32-bit displacement, with `base_used`=0 and `index_used`=0.
- R8: Mode 00 with scaled-index base field 101 (any `rex_b`) uses no base and a 32-bit displacement; in modes 01 and 10 the same field selects register {`rex_b`,101} as base.
- R9: A request with `req_lea`=1 raises `lea_done` and not `mem_req`; any other memory request raises `mem_req` and not `lea_done`.
- R10: With `req_addr32`=1 the address bits 63..32 are zero and bits 31..0 equal the low half of the full sum.
- R11: Mode 11 (register operand) yields no address: `ea_valid`, `mem_req` and `lea_done` stay 0.
- R12: Outputs are valid exactly one clock after an accepted request and for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_lea | input | 1 | Address-only request, no memory access |
| req_addr32 | input | 1 | 32-bit address size |
| mod_f | input | 2 | Mode field of operand byte |
| rm_f | input | 3 | Register-or-memory field of operand byte |
| sib_scale | input | 2 | Scale shift 0..3 |
| sib_index | input | 3 | Index field |
| sib_base | input | 3 | Base field |
| rex_x | input | 1 | Index extension bit |
| rex_b | input | 1 | Base extension bit |
| disp_raw | input | 32 | Raw displacement |
| cur_ip | input | 64 | Address of current instruction |
| insn_len | input | 4 | Length of current instruction |
| base_sel | output | 4 | Base register number to register file |
| index_sel | output | 4 | Index register number to register file |
| base_val | input | 64 | Base register value from register file |
| index_val | input | 64 | Index register value from register file |
| ea | output | 64 | Effective address |
| ea_valid | output | 1 | Address valid |
| mem_req | output | 1 | Memory access needed |
| lea_done | output | 1 | Address-only result ready |
| base_used | output | 1 | Base register took part |
| index_used | output | 1 | Index register took part |

## Verification
A wrong decode of a special encoding shows at the ports in the cycle after the request. A misread "no index" code, no-base code or IP-relative code changes `ea` by a whole register value or by the instruction address, and flips `base_used` or `index_used`. Because the output stage holds no state beyond one request, every fault is visible in that single result cycle. A wrong register number shows even earlier, on `base_sel` or `index_sel` in the request cycle. Faults in sign extension, scaling and truncation are provoked with register values whose upper halves are non-zero, with negative displacements and with an all-ones base.

// File: rtl/eag_pkg.sv
package eag_pkg;

   typedef enum logic [1:0] {
      DISP_NONE = 2'd0,
      DISP_BYTE = 2'd1,
      DISP_WORD = 2'd2
   } disp_kind_e;

   typedef struct packed {
      logic       is_mem;
      logic       use_base;
      logic       use_index;
      logic       use_ip;
      logic [3:0] base_id;
      logic [3:0] index_id;
      logic [1:0] shamt;
      disp_kind_e dkind;
   } ea_ctl_t;

   localparam logic [1:0] MODE_NODISP = 2'b00;
   localparam logic [1:0] MODE_BYTE   = 2'b01;
   localparam logic [1:0] MODE_WORD   = 2'b10;
   localparam logic [1:0] MODE_REG    = 2'b11;
   localparam logic [2:0] RM_SCALED   = 3'b100;
   localparam logic [2:0] RM_SPECIAL  = 3'b101;
   localparam logic [3:0] IDX_NONE    = 4'd4;

endpackage

// File: rtl/eag_decode.sv
module eag_decode
   import eag_pkg::*;
(
   input  logic [1:0] mod_f,
   input  logic [2:0] rm_f,
   input  logic [1:0] sib_scale,
   input  logic [2:0] sib_index,
   input  logic [2:0] sib_base,
   input  logic       rex_x,
   input  logic       rex_b,
   output ea_ctl_t    ctl
);
   logic scaled;
   logic ip_rel;
   logic no_base;
   logic [3:0] idx_num;

   always_comb begin
      scaled  = (rm_f == RM_SCALED);
      ip_rel  = !scaled && (mod_f == MODE_NODISP) && (rm_f == RM_SPECIAL);
      no_base = scaled && (mod_f == MODE_NODISP) && (sib_base == RM_SPECIAL);
      idx_num = {rex_x, sib_index};

      ctl.is_mem    = (mod_f != MODE_REG);
      ctl.use_ip    = ip_rel;
      ctl.use_base  = !ip_rel && !no_base;
      ctl.base_id   = scaled ? {rex_b, sib_base} : {rex_b, rm_f};
      ctl.index_id  = idx_num;
      ctl.use_index = scaled && (idx_num != IDX_NONE);
      ctl.shamt     = scaled ? sib_scale : 2'd0;

      case (mod_f)
         MODE_BYTE: ctl.dkind = DISP_BYTE;
         MODE_WORD: ctl.dkind = DISP_WORD;
         MODE_NODISP: ctl.dkind = (ip_rel || no_base) ? DISP_WORD : DISP_NONE;
         default:   ctl.dkind = DISP_NONE;
      endcase
   end
endmodule

// File: rtl/eag_disp.sv
module eag_disp
   import eag_pkg::*;
#(
   parameter int AW    = 64,
   parameter int DISPW = 32
)(
   input  disp_kind_e          kind,
   input  logic [DISPW-1:0]    raw,
   output logic [AW-1:0]       ext
);
   localparam int BYTE_PAD = AW - 8;
   localparam int WORD_PAD = AW - DISPW;

   if (DISPW < 8) begin : g_bad_dispw
      $error("eag_disp: DISPW must be at least 8");
   end
   if (AW <= DISPW) begin : g_bad_aw
      $error("eag_disp: AW must exceed DISPW");
   end

   logic [AW-1:0] byte_ext;
   logic [AW-1:0] word_ext;

   assign byte_ext = {{BYTE_PAD{raw[7]}}, raw[7:0]};
   assign word_ext = {{WORD_PAD{raw[DISPW-1]}}, raw};

   always_comb begin
      case (kind)
         DISP_BYTE: ext = byte_ext;
         DISP_WORD: ext = word_ext;
         default:   ext = '0;
      endcase
   end
endmodule

// File: rtl/eag_sum.sv
module eag_sum
   import eag_pkg::*;
#(
   parameter int AW        = 64,
   parameter bit ADDR32_EN = 1'b1
)(
   input  ea_ctl_t        ctl,
   input  logic [AW-1:0]  base_val,
   input  logic [AW-1:0]  index_val,
   input  logic [AW-1:0]  ip_next,
   input  logic [AW-1:0]  disp_ext,
   input  logic           addr32,
   output logic [AW-1:0]  addr
);
   localparam int NARROW = 32;

   logic [AW-1:0] base_term;
   logic [AW-1:0] index_term;
   logic [AW-1:0] full_sum;

   always_comb begin
      if (ctl.use_ip)        base_term = ip_next;
      else if (ctl.use_base) base_term = base_val;
      else                   base_term = '0;
      index_term = ctl.use_index ? (index_val << ctl.shamt) : '0;
      full_sum   = base_term + index_term + disp_ext;
   end

   if (ADDR32_EN) begin : g_trunc
      if (AW <= NARROW) begin : g_bad_aw
         $error("eag_sum: AW must exceed 32 when truncation is enabled");
      end
      assign addr = addr32 ? {{(AW-NARROW){1'b0}}, full_sum[NARROW-1:0]} : full_sum;
   end else begin : g_full
      logic unused_a32;
      assign unused_a32 = addr32;
      assign addr = full_sum;
   end
endmodule

// File: rtl/eag_top.sv
module eag_top
   import eag_pkg::*;
#(
   parameter int AW        = 64,
   parameter int DISPW     = 32,
   parameter int LENW      = 4,
   parameter bit ADDR32_EN = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_lea,
   input  logic             req_addr32,
   input  logic [1:0]       mod_f,
   input  logic [2:0]       rm_f,
   input  logic [1:0]       sib_scale,
   input  logic [2:0]       sib_index,
   input  logic [2:0]       sib_base,
   input  logic             rex_x,
   input  logic             rex_b,
   input  logic [DISPW-1:0] disp_raw,
   input  logic [AW-1:0]    cur_ip,
   input  logic [LENW-1:0]  insn_len,
   output logic [3:0]       base_sel,
   output logic [3:0]       index_sel,
   input  logic [AW-1:0]    base_val,
   input  logic [AW-1:0]    index_val,
   output logic [AW-1:0]    ea,
   output logic             ea_valid,
   output logic             mem_req,
   output logic             lea_done,
   output logic             base_used,
   output logic             index_used
);
   localparam int LEN_PAD = AW - LENW;

   if (LENW < 1 || LENW >= AW) begin : g_bad_lenw
      $error("eag_top: LENW out of range");
   end

   ea_ctl_t       ctl;
   logic [AW-1:0] disp_ext;
   logic [AW-1:0] ip_next;
   logic [AW-1:0] addr_d;
   logic          accept;

   eag_decode u_decode (
      .mod_f     (mod_f),
      .rm_f      (rm_f),
      .sib_scale (sib_scale),
      .sib_index (sib_index),
      .sib_base  (sib_base),
      .rex_x     (rex_x),
      .rex_b     (rex_b),
      .ctl       (ctl)
   );

   eag_disp #(.AW(AW), .DISPW(DISPW)) u_disp (
      .kind (ctl.dkind),
      .raw  (disp_raw),
      .ext  (disp_ext)
   );

   assign ip_next = cur_ip + {{LEN_PAD{1'b0}}, insn_len};

   eag_sum #(.AW(AW), .ADDR32_EN(ADDR32_EN)) u_sum (
      .ctl       (ctl),
      .base_val  (base_val),
      .index_val (index_val),
      .ip_next   (ip_next),
      .disp_ext  (disp_ext),
      .addr32    (req_addr32),
      .addr      (addr_d)
   );

   assign base_sel  = ctl.base_id;
   assign index_sel = ctl.index_id;
   assign accept    = req_valid && ctl.is_mem;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ea         <= '0;
         ea_valid   <= 1'b0;
         mem_req    <= 1'b0;
         lea_done   <= 1'b0;
         base_used  <= 1'b0;
         index_used <= 1'b0;
      end else begin
         ea_valid   <= accept;
         mem_req    <= accept && !req_lea;
         lea_done   <= accept && req_lea;
         base_used  <= accept && ctl.use_base;
         index_used <= accept && ctl.use_index;
         if (accept) ea <= addr_d;
      end
   end
endmodule

// File: rtl/eag_chk.sv
module eag_chk #(
   parameter int AW = 64
)(
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_lea,
   input logic          req_addr32,
   input logic [1:0]    mod_f,
   input logic [2:0]    rm_f,
   input logic          rex_x,
   input logic [2:0]    sib_index,
   input logic [AW-1:0] ea,
   input logic          ea_valid,
   input logic          mem_req,
   input logic          lea_done,
   input logic          base_used,
   input logic          index_used
);
   // R12
   valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ea_valid |-> $past(req_valid));

   // R11
   no_reg_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ea_valid |-> ($past(mod_f) != 2'b11));

   // R9
   one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req, lea_done}) && ((mem_req || lea_done) == ea_valid));

   // R9
   lea_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ea_valid && $past(req_lea)) |-> (lea_done && !mem_req));

   // R10
   narrow_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ea_valid && $past(req_addr32)) |-> (ea[AW-1:32] == '0));

   // R5
   no_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ea_valid && $past(rm_f == 3'b100 && {rex_x, sib_index} == 4'd4)) |-> !index_used);

   // R7
   ip_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ea_valid && $past(mod_f == 2'b00 && rm_f == 3'b101)) |-> (!base_used && !index_used));
endmodule

bind eag_top eag_chk #(.AW(AW)) u_eag_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_lea    (req_lea),
   .req_addr32 (req_addr32),
   .mod_f      (mod_f),
   .rm_f       (rm_f),
   .rex_x      (rex_x),
   .sib_index  (sib_index),
   .ea         (ea),
   .ea_valid   (ea_valid),
   .mem_req    (mem_req),
   .lea_done   (lea_done),
   .base_used  (base_used),
   .index_used (index_used)
);

// File: tb/test_eag_top.sv
module test_eag_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_lea = 1'b0, req_addr32 = 1'b0;
   logic [1:0]  mod_f = '0, sib_scale = '0;
   logic [2:0]  rm_f = '0, sib_index = '0, sib_base = '0;
   logic        rex_x = 1'b0, rex_b = 1'b0;
   logic [31:0] disp_raw = '0;
   logic [63:0] cur_ip = '0;
   logic [3:0]  insn_len = '0;
   logic [3:0]  base_sel, index_sel;
   logic [63:0] base_val, index_val, ea;
   logic        ea_valid, mem_req, lea_done, base_used, index_used;
   logic [63:0] rf [16];
   int          n_tests = 0, n_fail = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   assign base_val  = rf[base_sel];
   assign index_val = rf[index_sel];

   eag_top i_eag_top (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lea(req_lea),
      .req_addr32(req_addr32), .mod_f(mod_f), .rm_f(rm_f), .sib_scale(sib_scale),
      .sib_index(sib_index), .sib_base(sib_base), .rex_x(rex_x), .rex_b(rex_b),
      .disp_raw(disp_raw), .cur_ip(cur_ip), .insn_len(insn_len),
      .base_sel(base_sel), .index_sel(index_sel), .base_val(base_val),
      .index_val(index_val), .ea(ea), .ea_valid(ea_valid), .mem_req(mem_req),
      .lea_done(lea_done), .base_used(base_used), .index_used(index_used)
   );

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   // Drive one request at a falling edge; results are registered at the next
   // rising edge and sampled at the following falling edge.
   task automatic issue(input logic lea, input logic a32, input logic [1:0] md,
                        input logic [2:0] rm, input logic [1:0] sc, input logic [2:0] ix,
                        input logic [2:0] bs, input logic rx, input logic rb,
                        input logic [31:0] d, input logic [63:0] ip, input logic [3:0] len);
      @(negedge clk);
      req_lea = lea; req_addr32 = a32; mod_f = md; rm_f = rm; sib_scale = sc;
      sib_index = ix; sib_base = bs; rex_x = rx; rex_b = rb; disp_raw = d;
      cur_ip = ip; insn_len = len; req_valid = 1'b1;
      #1;
   endtask

   task automatic finish_req();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 ea_valid", {63'd0, ea_valid}, 64'd0);
      check("R1 ea", ea, 64'd0);
      check("R1 flags", {60'd0, mem_req, lea_done, base_used, index_used}, 64'd0);
   endtask

   task automatic t_indirect();
      issue(0, 0, 2'b00, 3'b011, 0, 0, 0, 0, 0, 32'h0, 0, 0);
      finish_req();
      check("R2 ea", ea, rf[3]);
      check("R2 used", {62'd0, base_used, index_used}, 64'd2);
      issue(0, 0, 2'b00, 3'b001, 0, 0, 0, 0, 1, 32'h0, 0, 0);
      check("R6 base_sel", {60'd0, base_sel}, 64'd9);
      finish_req();
      check("R6 ea r9", ea, rf[9]);
   endtask

   task automatic t_disp();
      issue(0, 0, 2'b01, 3'b010, 0, 0, 0, 0, 0, 32'h1234_56F0, 0, 0);
      finish_req();
      check("R3 disp8", ea, rf[2] - 64'd16);
      issue(0, 0, 2'b10, 3'b001, 0, 0, 0, 0, 0, 32'h8000_0000, 0, 0);
      finish_req();
      check("R3 disp32", ea, rf[1] + 64'hFFFF_FFFF_8000_0000);
      issue(0, 0, 2'b01, 3'b111, 0, 0, 0, 0, 1, 32'h0000_0002, 0, 0);
      finish_req();
      check("R3 wrap", ea, 64'd1);
   endtask

   task automatic t_scaled();
      for (int s = 0; s < 4; s++) begin
         issue(0, 0, 2'b00, 3'b100, 2'(s), 3'd6, 3'd0, 0, 0, 32'h0, 0, 0);
         finish_req();
         check("R4 scale", ea, rf[0] + (rf[6] << s));
      end
      issue(0, 0, 2'b10, 3'b100, 2'd2, 3'd3, 3'd2, 1, 1, 32'hFFFF_FF00, 0, 0);
      check("R6 index_sel", {60'd0, index_sel}, 64'd11);
      finish_req();
      check("R4 full", ea, rf[10] + (rf[11] << 2) - 64'd256);
      check("R4 used", {62'd0, base_used, index_used}, 64'd3);
   endtask

   task automatic t_noindex();
      issue(0, 0, 2'b00, 3'b100, 2'd3, 3'd4, 3'd1, 0, 0, 32'h0, 0, 0);
      finish_req();
      check("R5 none ea", ea, rf[1]);
      check("R5 none used", {63'd0, index_used}, 64'd0);
      issue(0, 0, 2'b00, 3'b100, 2'd1, 3'd4, 3'd1, 1, 0, 32'h0, 0, 0);
      finish_req();
      check("R5 r12 ea", ea, rf[1] + (rf[12] << 1));
      check("R5 r12 used", {63'd0, index_used}, 64'd1);
   endtask

   task automatic t_iprel();
      issue(0, 0, 2'b00, 3'b101, 0, 0, 0, 0, 1, 32'hFFFF_FFF0, 64'h40_0000, 4'd7);
      finish_req();
      check("R7 ea", ea, 64'h40_0000 + 64'd7 - 64'd16);
      check("R7 used", {62'd0, base_used, index_used}, 64'd0);
   endtask

   task automatic t_nobase();
      issue(0, 0, 2'b00, 3'b100, 2'd3, 3'd2, 3'd5, 0, 1, 32'h0000_1000, 0, 0);
      finish_req();
      check("R8 ea", ea, (rf[2] << 3) + 64'h1000);
      check("R8 used", {62'd0, base_used, index_used}, 64'd1);
      issue(0, 0, 2'b01, 3'b100, 2'd0, 3'd4, 3'd5, 0, 1, 32'h0000_0008, 0, 0);
      finish_req();
      check("R8 r13 base", ea, rf[13] + 64'd8);
   endtask

   task automatic t_lea();
      issue(1, 0, 2'b01, 3'b110, 0, 0, 0, 0, 0, 32'h0000_0020, 0, 0);
      finish_req();
      check("R9 lea ea", ea, rf[6] + 64'h20);
      check("R9 lea flags", {62'd0, lea_done, mem_req}, 64'd2);
      issue(0, 0, 2'b01, 3'b110, 0, 0, 0, 0, 0, 32'h0000_0020, 0, 0);
      finish_req();
      check("R9 mem flags", {62'd0, lea_done, mem_req}, 64'd1);
   endtask

   task automatic t_addr32();
      logic [63:0] full;
      full = rf[8] + (rf[3] << 1) + 64'hFFFF_FFFF_FFFF_FFFC;
      issue(0, 1, 2'b01, 3'b100, 2'd1, 3'd3, 3'd0, 0, 1, 32'h0000_00FC, 0, 0);
      finish_req();
      check("R10 ea", ea, {32'd0, full[31:0]});
   endtask

   task automatic t_regdirect();
      issue(0, 0, 2'b11, 3'b000, 0, 0, 0, 0, 0, 32'h0, 0, 0);
      finish_req();
      check("R11 flags", {61'd0, ea_valid, mem_req, lea_done}, 64'd0);
   endtask

   task automatic t_latency();
      issue(0, 0, 2'b00, 3'b000, 0, 0, 0, 0, 0, 32'h0, 0, 0);
      check("R12 not early", {63'd0, ea_valid}, 64'd0);
      finish_req();
      check("R12 on time", {63'd0, ea_valid}, 64'd1);
      @(negedge clk);
      check("R12 one cycle", {63'd0, ea_valid}, 64'd0);
   endtask

   initial begin
      for (int i = 0; i < 16; i++)
         rf[i] = {8'(i + 1), 24'h00_0A00, 32'h1000_0000 + 32'(i) * 32'h0000_0110};
      rf[15] = '1;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_indirect();
      t_disp();
      t_scaled();
      t_noindex();
      t_iprel();
      t_nobase();
      t_lea();
      t_addr32();
      t_regdirect();
      t_latency();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule